// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Falling-Edge Wake-up

This block is one general-purpose I/O port of a small microcontroller. Software reaches it over a simple single-cycle register bus. For each pin the port holds an output data latch, a direction bit, a pull-up enable and a wake-up enable. From these registers it drives the pad model with a per-pin output value, an output enable and a pull-up control. Pin levels pass through a two-flop synchroniser before anything inside the block uses them.

A read of the data register gives a mixed word. Pins set as outputs return the value held in their data latch. Pins set as inputs return their synchronised level. While the core's sleep input is high, a high-to-low change on any pin whose wake-up enable is set raises a wake-up request. That request stays high until sleep is released.

The register bus is a plain control path. Reads come straight from the address with no wait state, and writes land on the clock edge that samples the strobe. There is no stream traffic, so no valid/ready handshake applies and the bus never applies back-pressure.

Top module: `gpio_wake_port`

## Requirements
- R1: A direction bit of 1 makes its pin an input and 0 makes it an output; `pad_oe` of each pin is the inverse of its direction bit, and `pad_out` carries the data latch.
- R2: After reset the direction register reads 0xFF (all inputs, `pad_oe` = 0), the data latch, pull-up and wake-up enable registers read 0, and `wake_req` is 0.
- R3: A read of address 0 returns, for each output pin, the data latch bit, whatever the level on the pin.
- R4: A read of address 0 returns, for each input pin, the pin level after two flops: a change made between edges shows on the read after the second following rising edge, and not after the first.
- R5: Pull-up enable bits use 1 = enabled; `pad_pu` of a pin is high only while its pull-up enable is set and its direction bit is 1.
- R6: Pull-up bits at positions PULL_BITS and above (default PULL_BITS = 6, so bits 7 and 6) read as 0, ignore writes and never drive `pad_pu`.
- R7: While `sleep_i` is high, a high-to-low change on a pin whose wake-up enable bit is 1 sets `wake_req` at the third rising edge after the change; the request is the OR over all pins.
- R8: A falling pin with its wake-up enable at 0, and a rising pin, leave `wake_req` at 0.
- R9: `wake_req` stays high while `sleep_i` stays high, even after the pin returns high; it clears on the first rising edge that samples `sleep_i` low, and a falling edge seen while `sleep_i` is low never sets it.
- R10: Register map on the 2-bit address: 0 data latch, 1 direction, 2 pull-up enable, 3 wake-up enable; a write with `bus_wr` high takes effect at that rising edge, and `bus_rdata` follows `bus_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| pin_in | input | 8 | Levels on the pads, asynchronous |
| pad_out | output | 8 | Output value to each pad |
| pad_oe | output | 8 | Output enable to each pad, 1 = drive |
| pad_pu | output | 8 | Pull-up control to each pad, 1 = on |
| sleep_i | input | 1 | Core is in a low-power state |
| wake_req | output | 1 | Wake-up request to the core |

## Verification
A corrupted direction bit shows on `pad_oe` and in the mixed data read in the same cycle. A bad data latch shows on `pad_out` at once. A fault in the synchroniser or in the edge-history flop moves the input read off its second edge, or moves the wake request off its third edge, so each timing check samples the exact cycle and the one before it. A sticky flag that fails to hold or to clear shows on `wake_req` within one edge of the change on `sleep_i`.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PULL = 2'd2,
    SEL_WAKE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_wake_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int PULL_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  rdata,
  output logic [WIDTH-1:0]  data_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  pull_q,
  output logic [WIDTH-1:0]  wake_en_q
);
  localparam logic [WIDTH-1:0] PULL_MASK = {WIDTH{1'b1}} >> (WIDTH - PULL_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= '0;
      dir_q     <= '1;
      pull_q    <= '0;
      wake_en_q <= '0;
    end else if (wr) begin
      case (reg_sel_e'(addr))
        SEL_DATA: data_q    <= wdata;
        SEL_DIR:  dir_q     <= wdata;
        SEL_PULL: pull_q    <= wdata & PULL_MASK;
        SEL_WAKE: wake_en_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel_e'(addr))
      SEL_DATA: rdata = (dir_q & pin_sync) | (~dir_q & data_q);
      SEL_DIR:  rdata = dir_q;
      SEL_PULL: rdata = pull_q & PULL_MASK;
      SEL_WAKE: rdata = wake_en_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_wake_det.sv
module gpio_wake_det #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic [WIDTH-1:0] wake_en,
  input  logic             sleep,
  output logic             wake_req
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_sync;
  end

  assign fall = prev_q & ~pin_sync & wake_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wake_req <= 1'b0;
    else if (!sleep)  wake_req <= 1'b0;
    else if (|fall)   wake_req <= 1'b1;
  end
endmodule

// File: rtl/gpio_wake_port.sv
module gpio_wake_port
  import gpio_wake_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int PULL_BITS = 6,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_pu,
  input  logic              sleep_i,
  output logic              wake_req
);
  logic [WIDTH-1:0] pin_s;
  logic [WIDTH-1:0] data_q, dir_q, pull_q, wake_en_q;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_s)
  );

  gpio_regs #(.WIDTH(WIDTH), .PULL_BITS(PULL_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .pin_sync(pin_s), .rdata(bus_rdata),
    .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q), .wake_en_q(wake_en_q)
  );

  gpio_wake_det #(.WIDTH(WIDTH)) u_wake (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_s), .wake_en(wake_en_q),
    .sleep(sleep_i), .wake_req(wake_req)
  );

  assign pad_out = data_q;
  assign pad_oe  = ~dir_q;
  assign pad_pu  = pull_q & dir_q;
endmodule

// File: rtl/gpio_wake_chk.sv
module gpio_wake_chk
  import gpio_wake_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int PULL_BITS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  pad_pu,
  input logic              sleep_i,
  input logic              wake_req
);
  localparam logic [WIDTH-1:0] PULL_MASK = {WIDTH{1'b1}} >> (WIDTH - PULL_BITS);

  assert_dir_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == SEL_DIR) |=> (pad_oe == ~$past(bus_wdata)));

  assert_data_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == SEL_DATA) |=> (pad_out == $past(bus_wdata)));

  assert_out_read_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == SEL_DATA) |-> ((bus_rdata & pad_oe) == (pad_out & pad_oe)));

  assert_pull_input_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  assert_pull_unimpl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & ~PULL_MASK) == '0);

  assert_wake_needs_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> $past(sleep_i));

  assert_wake_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && sleep_i) |=> wake_req);

  assert_wake_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_i |=> !wake_req);
endmodule

bind gpio_wake_port gpio_wake_chk #(.WIDTH(WIDTH), .PULL_BITS(PULL_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .pad_pu(pad_pu), .sleep_i(sleep_i), .wake_req(wake_req)
);

// File: tb/sim_gpio_wake_port.sv
`timescale 1ns/1ps
module sim_gpio_wake_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pad_out, pad_oe, pad_pu;
  logic       sleep_i = 1'b0;
  logic       wake_req;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  gpio_wake_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .sleep_i(sleep_i), .wake_req(wake_req)
  );

  // {direction, data latch, pin level, expected read of address 0}
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    32'hFF_00_A5_A5,
    32'h00_3C_A5_3C,
    32'hF0_5A_33_3A,
    32'h0F_C3_96_C6,
    32'hAA_FF_00_55,
    32'h55_00_FF_55
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #0.5;
    d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    logic [7:0] r;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);

    // R2 reset state
    rd(2'd1, r); check("R2 dir reset", r, 8'hFF);
    rd(2'd0, r); check("R2 data read", r, 8'h00);
    rd(2'd2, r); check("R2 pull reset", r, 8'h00);
    rd(2'd3, r); check("R2 wake-en reset", r, 8'h00);
    check("R2 pad_oe", pad_oe, 8'h00);
    check("R2 pad_out", pad_out, 8'h00);
    check("R2 wake_req", {7'd0, wake_req}, 8'h00);

    // R1 R3 R10 table walk
    for (int v = 0; v < NV; v++) begin
      wr(2'd1, VEC[v][31:24]);
      wr(2'd0, VEC[v][23:16]);
      pin_in = VEC[v][15:8];
      cyc(3);
      rd(2'd0, r); check("R3/R4 mixed read", r, VEC[v][7:0]);
      check("R1 pad_oe", pad_oe, ~VEC[v][31:24]);
      check("R1 pad_out", pad_out, VEC[v][23:16]);
      rd(2'd1, r); check("R10 dir readback", r, VEC[v][31:24]);
    end

    // R4 two-flop timing
    wr(2'd1, 8'hFF);
    pin_in = 8'h00; cyc(3);
    pin_in = 8'hFF;
    cyc(1); rd(2'd0, r); check("R4 after one edge", r, 8'h00);
    cyc(1); rd(2'd0, r); check("R4 after two edges", r, 8'hFF);

    // R5 R6 pull-ups
    wr(2'd2, 8'hFF);
    rd(2'd2, r); check("R6 pull readback", r, 8'h3F);
    check("R5 pad_pu all inputs", pad_pu, 8'h3F);
    wr(2'd1, 8'h0F);
    check("R5 pad_pu gated by dir", pad_pu, 8'h0F);
    wr(2'd2, 8'hC0);
    rd(2'd2, r); check("R6 unimpl ignore", r, 8'h00);
    check("R5 pad_pu off", pad_pu, 8'h00);

    // R7 wake timing
    wr(2'd1, 8'hFF);
    wr(2'd3, 8'h01);
    rd(2'd3, r); check("R10 wake-en readback", r, 8'h01);
    pin_in = 8'hFF; cyc(4);
    sleep_i = 1'b1; cyc(1);
    pin_in = 8'hFE;
    cyc(1); check("R7 edge1", {7'd0, wake_req}, 8'h00);
    cyc(1); check("R7 edge2", {7'd0, wake_req}, 8'h00);
    cyc(1); check("R7 edge3", {7'd0, wake_req}, 8'h01);
    // R9 sticky and clear
    pin_in = 8'hFF; cyc(4);
    check("R9 sticky", {7'd0, wake_req}, 8'h01);
    sleep_i = 1'b0;
    cyc(1); check("R9 clear", {7'd0, wake_req}, 8'h00);

    // R8 disabled pin falls, enabled pin rises
    sleep_i = 1'b1; cyc(1);
    pin_in = 8'hFD; cyc(5);
    check("R8 disabled fall", {7'd0, wake_req}, 8'h00);
    pin_in = 8'hFC; cyc(4);
    sleep_i = 1'b0; cyc(1);
    sleep_i = 1'b1; cyc(1);
    pin_in = 8'hFD; cyc(5);
    check("R8 rising edge", {7'd0, wake_req}, 8'h00);

    // R9 fall while awake never sets later
    sleep_i = 1'b0; pin_in = 8'hFF; cyc(4);
    pin_in = 8'hFE; cyc(4);
    check("R9 awake fall", {7'd0, wake_req}, 8'h00);
    sleep_i = 1'b1; cyc(4);
    check("R9 no late set", {7'd0, wake_req}, 8'h00);

    // R7 OR across pins: bit 5 enabled
    sleep_i = 1'b0; wr(2'd3, 8'h21); pin_in = 8'hFF; cyc(4);
    sleep_i = 1'b1; cyc(1);
    pin_in = 8'hDF; cyc(3);
    check("R7 bit5 wake", {7'd0, wake_req}, 8'h01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule